// File: doc/BRIEF.md
# I2C Slave Receiver with Two-Phase 10-bit Address Match

This block is an I2C target that accepts write transfers addressed with 10-bit addresses. It runs on a fast system clock and oversamples the bus lines. It does not keep a fixed 10-bit address. It has one 8-bit compare register that a local host reloads during the transfer. The first address byte is checked against the high form held in the register. After a match the block raises an update flag and keeps SCL low until the host loads the low address byte. The second address byte is then checked against that value. Once it matches, the block raises the update flag again and holds SCL until the host restores the high form.

Data bytes that follow a full address match are acknowledged. Each one is handed to the host through a one-entry receive buffer with a valid/ready interface. rx_valid_o is high while a byte is waiting. A cycle with rx_ready_i high consumes it. The block applies back-pressure on the bus side: a byte that arrives while the buffer still holds an unread byte is not acknowledged and is dropped. The byte already in the buffer is kept. Clock stretching after each data byte is optional. When enabled, the clock-release bit drops and SCL stays low until the host sets the bit again. SCL and SDA are driven as open-drain pull-low enables.

Top module: `i2c10_rx_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) sets start_seen_o. It sets irq_o only when start_irq_en_i is high.
- R2: The first byte after a start matches when it equals {5'b11110, adr_q_o[2:1], 1'b0}, that is, prefix 11110, then A9:A8, then R/W clear. On a match, SDA is pulled low during the 9th SCL pulse, and upd_o and irq_o are set after that pulse. A mismatch is not acknowledged, sets no flag, and every byte is ignored until the next start.
- R3: After a high-byte match, scl_low_o stays high until the host writes the address register.
- R4: An address write issued while the block drives or decides the acknowledge bit, between the 8th and 9th SCL falling edges, is ignored and leaves adr_q_o unchanged.
- R5: The second address byte matches when it equals adr_q_o. It is then acknowledged, upd_o and irq_o are set, and SCL is held low until the next address write.
- R6: A second address byte that does not match is not acknowledged. It still sets upd_o and irq_o. It leaves rx_valid_o low, leaves clk_rel_o unchanged and does not hold SCL. Later bytes are ignored.
- R7: Each data byte after a full match is acknowledged on the 9th pulse. After that pulse, rx_data_o holds the byte (first bit on the bus is bit 7), rx_valid_o is set and irq_o is set.
- R8: With stretch_en_i high, each acknowledged data byte clears clk_rel_o, and scl_low_o stays high until a clk_rel_set_i pulse. With stretch_en_i low, SCL is not held after data bytes.
- R9: rx_ready_i clears rx_valid_o. A data byte arriving while rx_valid_o is high is not acknowledged, and rx_data_o keeps the earlier byte.
- R10: A stop condition (SDA rising while SCL is high) returns the block to idle and clears upd_o, start_seen_o and any address hold.
- R11: irq_clr_i clears irq_o and upd_clr_i clears upd_o. A hardware set in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pull SCL low (stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| stretch_en_i | input | 1 | Hold SCL after each data byte |
| start_irq_en_i | input | 1 | Raise irq_o on start conditions |
| adr_wr_i | input | 1 | Address register write strobe |
| adr_wdata_i | input | 8 | Address register write data |
| adr_q_o | output | 8 | Address register contents |
| clk_rel_set_i | input | 1 | Set the clock-release bit |
| clk_rel_o | output | 1 | Clock-release bit (1 = released) |
| irq_o | output | 1 | Interrupt flag |
| irq_clr_i | input | 1 | Clear interrupt flag |
| upd_o | output | 1 | Update-address flag |
| upd_clr_i | input | 1 | Clear update-address flag |
| start_seen_o | output | 1 | Start status |
| rx_data_o | output | 8 | Receive buffer data |
| rx_valid_o | output | 1 | Receive buffer holds an unread byte |
| rx_ready_i | input | 1 | Host consumes the buffered byte |

## Verification
A bus edge reaches the block's registers three system clocks after the line changes: two synchronizer stages, then one register stage that updates on the edge-detect pulse. Flags, the buffer, scl_low_o and sda_low_o therefore change in the third cycle after the SCL edge or the SDA edge that caused them. The bench master holds every SCL phase for at least eight cycles and samples four cycles after each edge it drives, on the falling clock edge, so every result has settled when it is read. Host strobes last exactly one cycle. Their effect is checked one cycle later.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI,
    ST_LO,
    ST_DATA,
    ST_SKIP
  } rx_state_e;

  localparam logic [4:0] HI_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c10_line_sync.sv
module i2c10_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic             scl_d, sda_d;

  assign raw = {scl_i, sda_i};

  // one synchronizer chain per bus line; lines idle high
  for (genvar g = 0; g < LINES; g++) begin : g_chain
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '1;
      else         sh <= {sh[STAGES-2:0], raw[g]};
    end
    assign synced[g] = sh[STAGES-1];
  end

  assign scl_o = synced[1];
  assign sda_o = synced[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_o;
      sda_d <= sda_o;
    end
  end

  assign scl_rise_o = scl_o && !scl_d;
  assign scl_fall_o = !scl_o && scl_d;
  assign start_o    = scl_o && scl_d && sda_d && !sda_o;
  assign stop_o     = scl_o && scl_d && !sda_d && sda_o;
endmodule

// File: rtl/i2c10_byte_shift.sv
module i2c10_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         enable_i,
  input  logic         scl_rise_i,
  input  logic         scl_fall_i,
  input  logic         sda_i,
  output logic [W-1:0] byte_o,
  output logic         decide_o,
  output logic         ack_done_o,
  output logic         in_ack_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(W);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic          ack_q;

  assign decide_o   = enable_i && scl_fall_i && !ack_q && (cnt_q == CNT_FULL);
  assign ack_done_o = enable_i && scl_fall_i && ack_q;
  assign byte_o     = sh_q;
  assign in_ack_o   = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else if (enable_i) begin
      if (scl_rise_i && !ack_q && (cnt_q != CNT_FULL)) begin
        sh_q  <= {sh_q[W-2:0], sda_i};
        cnt_q <= cnt_q + 1'b1;
      end
      if (decide_o) ack_q <= 1'b1;
      if (ack_done_o) begin
        ack_q <= 1'b0;
        cnt_q <= '0;
      end
    end
  end

  // the acknowledge window never opens before a full byte has been shifted
  AST_ACK_AFTER_FULL_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(cnt_q) == CNT_FULL); // R7
endmodule

// File: rtl/i2c10_rx_slave.sv
module i2c10_rx_slave
  import i2c10_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  input  logic       stretch_en_i,
  input  logic       start_irq_en_i,
  input  logic       adr_wr_i,
  input  logic [7:0] adr_wdata_i,
  output logic [7:0] adr_q_o,
  input  logic       clk_rel_set_i,
  output logic       clk_rel_o,
  output logic       irq_o,
  input  logic       irq_clr_i,
  output logic       upd_o,
  input  logic       upd_clr_i,
  output logic       start_seen_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i
);
  localparam int DW = 8;

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] byte_v;
  logic          decide, ack_done, in_ack, active;
  logic          verdict_c, verdict_q, ack_q, hold_q, ckp_q;
  logic          irq_q, upd_q, start_q, rx_valid_q, adr_acc;
  logic [DW-1:0] cmp_q, rx_q;
  rx_state_e     st_q;

  i2c10_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign active = (st_q == ST_HI) || (st_q == ST_LO) || (st_q == ST_DATA);

  i2c10_byte_shift #(.W(DW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(start_det || stop_det),
    .enable_i(active), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .byte_o(byte_v), .decide_o(decide), .ack_done_o(ack_done), .in_ack_o(in_ack)
  );

  // acknowledge decision taken at the end of the 8th bit
  always_comb begin
    unique case (st_q)
      ST_HI:   verdict_c = (byte_v[7:3] == HI_PREFIX) && (byte_v[7:1] == cmp_q[7:1]) && !byte_v[0];
      ST_LO:   verdict_c = (byte_v == cmp_q);
      ST_DATA: verdict_c = !rx_valid_q;
      default: verdict_c = 1'b0;
    endcase
  end

  assign adr_acc = adr_wr_i && !in_ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cmp_q      <= '0;
      rx_q       <= '0;
      rx_valid_q <= 1'b0;
      verdict_q  <= 1'b0;
      ack_q      <= 1'b0;
      hold_q     <= 1'b0;
      ckp_q      <= 1'b1;
      irq_q      <= 1'b0;
      upd_q      <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      if (adr_acc) begin
        cmp_q  <= adr_wdata_i;
        hold_q <= 1'b0;
      end
      if (clk_rel_set_i) ckp_q <= 1'b1;
      if (irq_clr_i)     irq_q <= 1'b0;
      if (upd_clr_i)     upd_q <= 1'b0;
      if (rx_ready_i)    rx_valid_q <= 1'b0;
      if (decide) begin
        verdict_q <= verdict_c;
        ack_q     <= verdict_c;
      end
      if (ack_done) begin
        ack_q <= 1'b0;
        unique case (st_q)
          ST_HI: begin
            if (verdict_q) begin
              upd_q <= 1'b1; irq_q <= 1'b1; hold_q <= 1'b1; st_q <= ST_LO;
            end else st_q <= ST_SKIP;
          end
          ST_LO: begin
            upd_q <= 1'b1;
            irq_q <= 1'b1;
            if (verdict_q) begin
              hold_q <= 1'b1; st_q <= ST_DATA;
            end else st_q <= ST_SKIP;
          end
          ST_DATA: begin
            if (verdict_q) begin
              rx_q       <= byte_v;
              rx_valid_q <= 1'b1;
              irq_q      <= 1'b1;
              if (stretch_en_i) ckp_q <= 1'b0;
            end else st_q <= ST_SKIP;
          end
          default: ;
        endcase
      end
      if (start_det) begin
        st_q    <= ST_HI;
        start_q <= 1'b1;
        ack_q   <= 1'b0;
        if (start_irq_en_i) irq_q <= 1'b1;
      end
      if (stop_det) begin
        st_q    <= ST_IDLE;
        start_q <= 1'b0;
        upd_q   <= 1'b0;
        hold_q  <= 1'b0;
        ack_q   <= 1'b0;
      end
    end
  end

  assign scl_low_o    = hold_q || !ckp_q;
  assign sda_low_o    = ack_q;
  assign adr_q_o      = cmp_q;
  assign clk_rel_o    = ckp_q;
  assign irq_o        = irq_q;
  assign upd_o        = upd_q;
  assign start_seen_o = start_q;
  assign rx_data_o    = rx_q;
  assign rx_valid_o   = rx_valid_q;

  AST_ACK_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> !$past(scl_s)); // R2
  AST_HOLD_UNTIL_ADR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !adr_acc && !stop_det) |=> hold_q); // R3
  AST_ADR_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ack && adr_wr_i) |=> $stable(cmp_q)); // R4
  AST_LO_MISS_NO_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_done && st_q == ST_LO && !verdict_q && !rx_valid_q) |=> !rx_valid_q); // R6
  AST_FULL_BUFFER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_q && !rx_ready_i) |=> $stable(rx_q)); // R9
  AST_STOP_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (st_q == ST_IDLE) && !upd_q && !hold_q); // R10
endmodule

// File: tb/i2c10_rx_slave_tb_top.sv
module i2c10_rx_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_low, sda_low;
  logic       stretch_en = 1'b0, start_irq_en = 1'b0;
  logic       adr_wr = 1'b0, rel_set = 1'b0, irq_clr = 1'b0, upd_clr = 1'b0, rx_ready = 1'b0;
  logic [7:0] adr_wdata = '0, adr_q, rx_data;
  logic       clk_rel, irq, upd, start_seen, rx_valid;
  logic       scl_line, sda_line;
  int         checks = 0, errors = 0, cycles = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  assign scl_line = scl_m & ~scl_low;
  assign sda_line = sda_m & ~sda_low;

  i2c10_rx_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .stretch_en_i(stretch_en),
    .start_irq_en_i(start_irq_en), .adr_wr_i(adr_wr), .adr_wdata_i(adr_wdata),
    .adr_q_o(adr_q), .clk_rel_set_i(rel_set), .clk_rel_o(clk_rel), .irq_o(irq),
    .irq_clr_i(irq_clr), .upd_o(upd), .upd_clr_i(upd_clr), .start_seen_o(start_seen),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_adr(input logic [7:0] v);
    adr_wdata = v; adr_wr = 1'b1; @(negedge clk); adr_wr = 1'b0;
  endtask

  task automatic host_pulse_rel();   rel_set = 1'b1;  @(negedge clk); rel_set = 1'b0;  endtask
  task automatic host_clear_flags(); irq_clr = 1'b1; upd_clr = 1'b1; @(negedge clk);
                                     irq_clr = 1'b0; upd_clr = 1'b0; endtask
  task automatic host_read();        rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(4);
    scl_m = 1'b1; wait_n(8);
    sda_m = 1'b0; wait_n(8);
    scl_m = 1'b0; wait_n(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(4);
    scl_m = 1'b1; wait_n(8);
    sda_m = 1'b1; wait_n(8);
  endtask

  // one SCL pulse; returns the SDA level seen while SCL is high
  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; wait_n(4);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_n(4);
    r = sda_line;
    wait_n(4);
    scl_m = 1'b0; wait_n(4);
  endtask

  // eight data bits then the acknowledge pulse; optional address write inside the ack window
  task automatic bus_byte(input logic [7:0] v, output logic acked,
                          input bit blk_wr = 1'b0, input logic [7:0] blk_val = 8'h00);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
    if (blk_wr) host_adr(blk_val);
    bus_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic t_reset_state();
    check("R10 reset scl_low", scl_low, 0);
    check("R10 reset sda_low", sda_low, 0);
    check("R9 reset rx_valid", rx_valid, 0);
    check("R11 reset irq", irq, 0);
    check("R11 reset upd", upd, 0);
    check("R8 reset clk_rel", clk_rel, 1);
    check("R1 reset start_seen", start_seen, 0);
  endtask

  task automatic t_start_status();
    start_irq_en = 1'b0;
    bus_start();
    check("R1 start_seen", start_seen, 1);
    check("R1 no irq when disabled", irq, 0);
    bus_stop();
    check("R10 stop clears start_seen", start_seen, 0);
    start_irq_en = 1'b1;
    bus_start();
    check("R1 irq when enabled", irq, 1);
    bus_stop();
    start_irq_en = 1'b0;
    host_clear_flags();
    check("R11 irq cleared", irq, 0);
  endtask

  task automatic t_hi_miss();
    logic a;
    host_adr(8'hF4);
    bus_start();
    bus_byte(8'hF6, a);
    check("R2 high mismatch nack", a, 0);
    check("R2 high mismatch no upd", upd, 0);
    check("R2 high mismatch no irq", irq, 0);
    bus_byte(8'hF4, a);
    check("R2 ignored until start", a, 0);
    bus_stop();
    bus_start();
    bus_byte(8'hF5, a);
    check("R2 R/W set rejected", a, 0);
    bus_stop();
  endtask

  task automatic t_full_write();
    logic a;
    bus_start();
    bus_byte(8'hF4, a, 1'b1, 8'hAA);
    check("R2 high match ack", a, 1);
    check("R4 write in ack window ignored", adr_q, 8'hF4);
    check("R2 upd after high", upd, 1);
    check("R2 irq after high", irq, 1);
    check("R3 scl held after high", scl_low, 1);
    wait_n(10);
    check("R3 scl still held", scl_low, 1);
    host_adr(8'h5A);
    check("R3 write releases scl", scl_low, 0);
    check("R3 register loaded", adr_q, 8'h5A);
    host_clear_flags();
    check("R11 upd cleared", upd, 0);
    bus_byte(8'h5A, a);
    check("R5 low match ack", a, 1);
    check("R5 upd after low", upd, 1);
    check("R5 irq after low", irq, 1);
    check("R5 scl held after low", scl_low, 1);
    host_adr(8'hF4);
    host_clear_flags();
    bus_byte(8'h3C, a);
    check("R7 data ack", a, 1);
    check("R7 rx_valid", rx_valid, 1);
    check("R7 rx_data", rx_data, 8'h3C);
    check("R7 irq after data", irq, 1);
    check("R8 no hold without stretch", scl_low, 0);
    bus_byte(8'hC3, a);
    check("R9 full buffer nack", a, 0);
    check("R9 buffer kept", rx_data, 8'h3C);
    bus_stop();
    check("R10 stop clears upd", upd, 0);
  endtask

  task automatic t_stretch();
    logic a;
    host_read();
    check("R9 ready clears valid", rx_valid, 0);
    stretch_en = 1'b1;
    bus_start();
    bus_byte(8'hF4, a);
    host_adr(8'h5A);
    bus_byte(8'h5A, a);
    host_adr(8'hF4);
    bus_byte(8'h81, a);
    check("R8 stretched data ack", a, 1);
    check("R8 clk_rel cleared", clk_rel, 0);
    check("R8 scl held", scl_low, 1);
    check("R7 data stored", rx_data, 8'h81);
    host_pulse_rel();
    check("R8 release bit set", clk_rel, 1);
    check("R8 scl released", scl_low, 0);
    host_read();
    bus_stop();
    stretch_en = 1'b0;
  endtask

  task automatic t_lo_miss();
    logic a;
    host_clear_flags();
    bus_start();
    bus_byte(8'hF4, a);
    host_adr(8'h5A);
    host_clear_flags();
    bus_byte(8'h77, a);
    check("R6 low mismatch nack", a, 0);
    check("R6 upd still set", upd, 1);
    check("R6 irq still set", irq, 1);
    check("R6 no buffer full", rx_valid, 0);
    check("R6 clk_rel unchanged", clk_rel, 1);
    check("R6 no scl hold", scl_low, 0);
    bus_byte(8'h5A, a);
    check("R6 later bytes ignored", a, 0);
    bus_stop();
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    t_reset_state();
    t_start_status();
    t_hi_miss();
    t_full_write();
    t_stretch();
    t_lo_miss();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule